// File: doc/BRIEF.md
# Holding-Register Byte FIFO Pair

This block sits behind the transmit and receive holding registers of a serial controller and gives each direction a byte-wide FIFO. The bus side may write 1, 2 or 4 bytes to the transmit side in a single access, and may read 1, 2 or 4 bytes from the receive side in a single access. In both cases the byte in lane [7:0] is the oldest one. The serial shifter takes bytes from the transmit FIFO one at a time and places received bytes into the receive FIFO one at a time.

Each direction has a ready flag that a DMA engine can use as its request line. Each flag has a programmable threshold, so the request rises only when one, two or four entries can be moved. Control strobes switch the FIFOs on and off and flush each FIFO. A level word reports both fill counts. When the FIFOs are switched off, each direction behaves like a single holding register.

Top module: `hold_fifo_pair`

## Requirements
- R1: After reset the FIFOs are off, both counts are zero, both thresholds are 0, the overflow and underflow flags are clear, tx_ready is 1, rx_ready is 0 and sh_tx_valid is 0.
- R2: With the FIFOs on, a transmit write of size 0 (byte), 1 (half) or 2 and 3 (word) pushes 1, 2 or 4 bytes. Lane [7:0] is pushed first and reaches the shifter first.
- R3: With the FIFOs on, a receive read of size 0, 1, or 2 and 3 pops 1, 2 or 4 bytes. Lane k of rhr_rdata holds the k-th oldest stored byte, and lanes not requested read as zero.
- R4: With the FIFOs off, each direction holds at most one byte. Any access size moves only the byte in lane [7:0]. A byte access behaves the same whether the FIFOs are on or off.
- R5: The transmit threshold encodes 0 as one entry, 1 as two, 2 as four and 3 as one. With the FIFOs on, tx_ready is high exactly when the free entries are at least that number.
- R6: The receive threshold uses the same encoding. With the FIFOs on, rx_ready is high exactly when the stored entries are at least that number.
- R7: A transmit write that needs more entries than are free at the start of the cycle is dropped whole and sets the sticky tx_ovf flag. This holds even when the shifter pops in the same cycle.
- R8: A receive read that asks for more bytes than are stored pops only the stored bytes and returns zero in the missing lanes. It also sets the sticky rx_unf flag.
- R9: ctl_tx_flush empties the transmit FIFO and clears tx_ovf. ctl_rx_flush empties the receive FIFO and clears rx_unf. ctl_fifo_on and ctl_fifo_off each empty both FIFOs and clear both flags; if both arrive in the same cycle, off wins. A flush discards a push made in the same cycle.
- R10: level_o carries the transmit count in bits [5:0] and the receive count in bits [21:16]. All other bits are zero.
- R11: sh_tx_valid is high while the transmit FIFO is not empty, and sh_tx_byte is the oldest byte. A pop from an empty transmit FIFO is ignored. A shifter push into a full receive FIFO is dropped, and the count stays at the depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctl_fifo_on | input | 1 | Strobe: switch FIFOs on |
| ctl_fifo_off | input | 1 | Strobe: switch FIFOs off |
| ctl_tx_flush | input | 1 | Strobe: empty transmit FIFO |
| ctl_rx_flush | input | 1 | Strobe: empty receive FIFO |
| mode_wr | input | 1 | Load both thresholds |
| tx_thr_wdata | input | 2 | Transmit threshold code |
| rx_thr_wdata | input | 2 | Receive threshold code |
| thr_wr | input | 1 | Transmit holding register write |
| thr_size | input | 2 | Write size: 0 byte, 1 half, 2/3 word |
| thr_wdata | input | 32 | Write data, lane [7:0] oldest |
| rhr_rd | input | 1 | Receive holding register read |
| rhr_size | input | 2 | Read size: 0 byte, 1 half, 2/3 word |
| rhr_rdata | output | 32 | Read data, lane [7:0] oldest |
| tx_ready | output | 1 | Transmit room meets threshold |
| rx_ready | output | 1 | Receive fill meets threshold |
| tx_ovf | output | 1 | Sticky transmit overflow |
| rx_unf | output | 1 | Sticky receive underflow |
| level_o | output | 32 | Fill counts: tx [5:0], rx [21:16] |
| sh_tx_pop | input | 1 | Shifter takes one transmit byte |
| sh_tx_valid | output | 1 | Transmit FIFO not empty |
| sh_tx_byte | output | 8 | Oldest transmit byte |
| sh_rx_push | input | 1 | Shifter delivers one received byte |
| sh_rx_byte | input | 8 | Received byte |

## Verification
On the transmit side, a bus write and a shifter pop can land in the same cycle. On the receive side, a shifter push and a bus read can land in the same cycle. The overflow rule depends on which of the two is judged first. The bench fills the transmit FIFO to its depth and then, in one cycle, raises sh_tx_pop together with a one-byte write. It expects the write to be dropped, the count to fall by exactly one and tx_ovf to rise. A flush raised in the same cycle as a write is checked the same way: the count must end at zero.

// File: rtl/hfifo_pkg.sv
package hfifo_pkg;

   localparam int unsigned LANES = 4;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_WIDE = 2'd3
   } acc_size_e;

   // Bytes moved by one access of the given size
   function automatic logic [2:0] lanes_of(input logic [1:0] sz);
      case (acc_size_e'(sz))
         SZ_BYTE: lanes_of = 3'd1;
         SZ_HALF: lanes_of = 3'd2;
         default: lanes_of = 3'd4;
      endcase
   endfunction

   // Entries a threshold code asks for; code 3 behaves as one
   function automatic logic [2:0] need_of(input logic [1:0] thr);
      case (thr)
         2'd1:    need_of = 3'd2;
         2'd2:    need_of = 3'd4;
         default: need_of = 3'd1;
      endcase
   endfunction

endpackage

// File: rtl/hf_byte_fifo.sv
module hf_byte_fifo
   import hfifo_pkg::*;
#(
   parameter int unsigned DEPTH = 32,
   localparam int unsigned AW = $clog2(DEPTH),
   localparam int unsigned CW = $clog2(DEPTH + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic [2:0]           push_n,
   input  logic [8*LANES-1:0]   push_data,
   input  logic [2:0]           pop_n,
   output logic [8*LANES-1:0]   head,
   output logic [CW-1:0]        count
);

   if ((DEPTH & (DEPTH - 1)) != 0) begin : g_bad_pow2
      $error("hf_byte_fifo: DEPTH must be a power of two");
   end
   if (DEPTH < LANES) begin : g_bad_small
      $error("hf_byte_fifo: DEPTH must hold at least one word");
   end

   logic [7:0]    mem [DEPTH];
   logic [AW-1:0] wr_ptr;
   logic [AW-1:0] rd_ptr;

   always_ff @(posedge clk) begin
      for (int k = 0; k < LANES; k++) begin
         if (3'(k) < push_n) begin
            mem[wr_ptr + AW'(k)] <= push_data[8*k +: 8];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         wr_ptr <= wr_ptr + AW'(push_n);
         rd_ptr <= rd_ptr + AW'(pop_n);
         count  <= count + CW'(push_n) - CW'(pop_n);
      end
   end

   always_comb begin
      for (int k = 0; k < LANES; k++) begin
         head[8*k +: 8] = (CW'(k) < count) ? mem[rd_ptr + AW'(k)] : 8'h00;
      end
   end

   AST_PUSH_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
      CW'(push_n) <= CW'(DEPTH) - count); // R7
   AST_POP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      CW'(pop_n) <= count); // R8
   AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH)); // R11

endmodule

// File: rtl/hf_ready_gate.sv
module hf_ready_gate
   import hfifo_pkg::*;
#(
   parameter int unsigned DEPTH = 32,
   parameter bit          IS_TX = 1'b1,
   localparam int unsigned CW = $clog2(DEPTH + 1)
) (
   input  logic          on,
   input  logic [CW-1:0] cnt,
   input  logic [1:0]    thr,
   output logic          ready
);

   logic [2:0] need;
   assign need = on ? need_of(thr) : 3'd1;

   if (IS_TX) begin : g_room
      logic [CW-1:0] free;
      assign free  = (on ? CW'(DEPTH) : CW'(1)) - cnt;
      assign ready = free >= CW'(need);
   end else begin : g_fill
      assign ready = cnt >= CW'(need);
   end

endmodule

// File: rtl/hold_fifo_pair.sv
module hold_fifo_pair
   import hfifo_pkg::*;
#(
   parameter int unsigned DEPTH = 32,
   localparam int unsigned CW = $clog2(DEPTH + 1)
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        ctl_fifo_on,
   input  logic        ctl_fifo_off,
   input  logic        ctl_tx_flush,
   input  logic        ctl_rx_flush,
   input  logic        mode_wr,
   input  logic [1:0]  tx_thr_wdata,
   input  logic [1:0]  rx_thr_wdata,
   input  logic        thr_wr,
   input  logic [1:0]  thr_size,
   input  logic [31:0] thr_wdata,
   input  logic        rhr_rd,
   input  logic [1:0]  rhr_size,
   output logic [31:0] rhr_rdata,
   output logic        tx_ready,
   output logic        rx_ready,
   output logic        tx_ovf,
   output logic        rx_unf,
   output logic [31:0] level_o,
   input  logic        sh_tx_pop,
   output logic        sh_tx_valid,
   output logic [7:0]  sh_tx_byte,
   input  logic        sh_rx_push,
   input  logic [7:0]  sh_rx_byte
);

   if (CW > 6) begin : g_bad_level
      $error("hold_fifo_pair: counts must fit the 6-bit level fields");
   end

   logic          fifo_on;
   logic [1:0]    tx_thr, rx_thr;
   logic          mode_sw, tx_clr, rx_clr;
   logic [CW-1:0] cap_now, tx_cnt, rx_cnt, tx_free;
   logic [2:0]    tx_req_n, rx_req_n;
   logic [2:0]    tx_push_n, tx_pop_n, rx_push_n, rx_pop_n;
   logic          tx_fits, rx_short;
   logic [31:0]   tx_head, rx_head;

   assign mode_sw = ctl_fifo_on | ctl_fifo_off;
   assign tx_clr  = ctl_tx_flush | mode_sw;
   assign rx_clr  = ctl_rx_flush | mode_sw;
   assign cap_now = fifo_on ? CW'(DEPTH) : CW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fifo_on <= 1'b0;
      end else if (ctl_fifo_off) begin
         fifo_on <= 1'b0;
      end else if (ctl_fifo_on) begin
         fifo_on <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_thr <= 2'd0;
         rx_thr <= 2'd0;
      end else if (mode_wr) begin
         tx_thr <= tx_thr_wdata;
         rx_thr <= rx_thr_wdata;
      end
   end

   // Transmit side: bus pushes, shifter pops one byte
   assign tx_req_n  = fifo_on ? lanes_of(thr_size) : 3'd1;
   assign tx_free   = cap_now - tx_cnt;
   assign tx_fits   = CW'(tx_req_n) <= tx_free;
   assign tx_push_n = (thr_wr && !tx_clr && tx_fits) ? tx_req_n : 3'd0;
   assign tx_pop_n  = (sh_tx_pop && (tx_cnt != '0) && !tx_clr) ? 3'd1 : 3'd0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_ovf <= 1'b0;
      end else if (tx_clr) begin
         tx_ovf <= 1'b0;
      end else if (thr_wr && !tx_fits) begin
         tx_ovf <= 1'b1;
      end
   end

   hf_byte_fifo #(.DEPTH(DEPTH)) i_tx_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (tx_clr),
      .push_n    (tx_push_n),
      .push_data (thr_wdata),
      .pop_n     (tx_pop_n),
      .head      (tx_head),
      .count     (tx_cnt)
   );

   assign sh_tx_valid = (tx_cnt != '0);
   assign sh_tx_byte  = tx_head[7:0];

   // Receive side: shifter pushes one byte, bus pops
   assign rx_req_n  = fifo_on ? lanes_of(rhr_size) : 3'd1;
   assign rx_short  = CW'(rx_req_n) > rx_cnt;
   assign rx_push_n = (sh_rx_push && !rx_clr && (rx_cnt < cap_now)) ? 3'd1 : 3'd0;
   assign rx_pop_n  = (rhr_rd && !rx_clr) ?
                      (rx_short ? 3'(rx_cnt) : rx_req_n) : 3'd0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_unf <= 1'b0;
      end else if (rx_clr) begin
         rx_unf <= 1'b0;
      end else if (rhr_rd && rx_short) begin
         rx_unf <= 1'b1;
      end
   end

   hf_byte_fifo #(.DEPTH(DEPTH)) i_rx_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (rx_clr),
      .push_n    (rx_push_n),
      .push_data ({24'h0, sh_rx_byte}),
      .pop_n     (rx_pop_n),
      .head      (rx_head),
      .count     (rx_cnt)
   );

   always_comb begin
      for (int k = 0; k < LANES; k++) begin
         rhr_rdata[8*k +: 8] = (3'(k) < rx_req_n) ? rx_head[8*k +: 8] : 8'h00;
      end
   end

   // Ready gates, one variant per direction
   hf_ready_gate #(.DEPTH(DEPTH), .IS_TX(1'b1)) i_tx_gate (
      .on    (fifo_on),
      .cnt   (tx_cnt),
      .thr   (tx_thr),
      .ready (tx_ready)
   );

   hf_ready_gate #(.DEPTH(DEPTH), .IS_TX(1'b0)) i_rx_gate (
      .on    (fifo_on),
      .cnt   (rx_cnt),
      .thr   (rx_thr),
      .ready (rx_ready)
   );

   always_comb begin
      level_o = '0;
      level_o[CW-1:0]  = tx_cnt;
      level_o[16 +: CW] = rx_cnt;
   end

   AST_TXCLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_tx_flush |=> (tx_cnt == '0)); // R9
   AST_RXCLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_rx_flush |=> (rx_cnt == '0)); // R9
   AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_ovf && !tx_clr) |=> tx_ovf); // R7
   AST_OFF_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_on |-> (tx_cnt <= CW'(1) && rx_cnt <= CW'(1))); // R4
   AST_TX_FOUR_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_on && tx_thr == 2'd2 && tx_ready) |-> (tx_cnt <= CW'(DEPTH - 4))); // R5
   AST_RX_FOUR_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_on && rx_thr == 2'd2 && rx_ready) |-> (rx_cnt >= CW'(4))); // R6

endmodule

// File: tb/test_hold_fifo_pair.sv
module test_hold_fifo_pair;

   localparam int DEPTH = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_fifo_on = 0, ctl_fifo_off = 0, ctl_tx_flush = 0, ctl_rx_flush = 0;
   logic        mode_wr = 0;
   logic [1:0]  tx_thr_wdata = 0, rx_thr_wdata = 0;
   logic        thr_wr = 0;
   logic [1:0]  thr_size = 0;
   logic [31:0] thr_wdata = 0;
   logic        rhr_rd = 0;
   logic [1:0]  rhr_size = 0;
   logic [31:0] rhr_rdata;
   logic        tx_ready, rx_ready, tx_ovf, rx_unf;
   logic [31:0] level_o;
   logic        sh_tx_pop = 0;
   logic        sh_tx_valid;
   logic [7:0]  sh_tx_byte;
   logic        sh_rx_push = 0;
   logic [7:0]  sh_rx_byte = 0;

   int n_chk = 0;
   int n_err = 0;
   bit done = 0;

   always #4 clk = ~clk;

   hold_fifo_pair #(.DEPTH(DEPTH)) i_hold_fifo_pair (
      .clk, .rst_n, .ctl_fifo_on, .ctl_fifo_off, .ctl_tx_flush, .ctl_rx_flush,
      .mode_wr, .tx_thr_wdata, .rx_thr_wdata, .thr_wr, .thr_size, .thr_wdata,
      .rhr_rd, .rhr_size, .rhr_rdata, .tx_ready, .rx_ready, .tx_ovf, .rx_unf,
      .level_o, .sh_tx_pop, .sh_tx_valid, .sh_tx_byte, .sh_rx_push, .sh_rx_byte
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr_tx(input logic [1:0] sz, input logic [31:0] d);
      @(negedge clk); thr_wr = 1; thr_size = sz; thr_wdata = d;
      @(negedge clk); thr_wr = 0; #1;
   endtask

   task automatic rd_rx(input logic [1:0] sz, output logic [31:0] d);
      @(negedge clk); rhr_rd = 1; rhr_size = sz; #1; d = rhr_rdata;
      @(negedge clk); rhr_rd = 0; #1;
   endtask

   task automatic push_rx(input logic [7:0] b);
      @(negedge clk); sh_rx_push = 1; sh_rx_byte = b;
      @(negedge clk); sh_rx_push = 0; #1;
   endtask

   task automatic pop_tx(output logic [7:0] b);
      @(negedge clk); sh_tx_pop = 1; #1; b = sh_tx_byte;
      @(negedge clk); sh_tx_pop = 0; #1;
   endtask

   task automatic set_thr(input logic [1:0] t, input logic [1:0] r);
      @(negedge clk); mode_wr = 1; tx_thr_wdata = t; rx_thr_wdata = r;
      @(negedge clk); mode_wr = 0; #1;
   endtask

   task automatic ctl(input bit on, input bit off, input bit tf, input bit rf);
      @(negedge clk); ctl_fifo_on = on; ctl_fifo_off = off; ctl_tx_flush = tf; ctl_rx_flush = rf;
      @(negedge clk); ctl_fifo_on = 0; ctl_fifo_off = 0; ctl_tx_flush = 0; ctl_rx_flush = 0; #1;
   endtask

   task automatic t_reset;
      check("R1 level", level_o, 32'h0);
      check("R1 tx_ready", 32'(tx_ready), 32'h1);
      check("R1 rx_ready", 32'(rx_ready), 32'h0);
      check("R1 flags", {30'h0, tx_ovf, rx_unf}, 32'h0);
      check("R1 sh_tx_valid", 32'(sh_tx_valid), 32'h0);
   endtask

   task automatic t_fifo_off;
      logic [7:0] b; logic [31:0] d;
      wr_tx(2'd2, 32'hAABBCCDD);
      check("R4 off word write level", level_o, 32'h1);
      check("R4 off word lane0", 32'(sh_tx_byte), 32'hDD);
      wr_tx(2'd0, 32'h00000055);
      check("R7 off second byte dropped", level_o, 32'h1);
      check("R7 off ovf", 32'(tx_ovf), 32'h1);
      pop_tx(b);
      check("R4 off pop byte", 32'(b), 32'hDD);
      push_rx(8'h11); push_rx(8'h22);
      check("R4 off rx holds one", level_o, 32'h0001_0000);
      rd_rx(2'd2, d);
      check("R4 off word read lane0 only", d, 32'h11);
      check("R4 off rx empty", level_o, 32'h0);
      ctl(0, 0, 1, 0);
      check("R9 tx flush clears ovf", 32'(tx_ovf), 32'h0);
   endtask

   task automatic t_tx_order;
      logic [7:0] b;
      logic [7:0] exp_b [7] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77};
      ctl(1, 0, 0, 0);
      wr_tx(2'd2, 32'h44332211);
      wr_tx(2'd1, 32'hFFFF6655);
      wr_tx(2'd0, 32'hFFFFFF77);
      check("R2 tx level 7", level_o, 32'd7);
      for (int i = 0; i < 7; i++) begin
         pop_tx(b);
         check("R2 R11 tx byte order", 32'(b), 32'(exp_b[i]));
      end
      check("R11 tx empty valid", 32'(sh_tx_valid), 32'h0);
      pop_tx(b);
      check("R11 pop on empty ignored", level_o, 32'h0);
   endtask

   task automatic t_rx_word;
      logic [31:0] d;
      for (int i = 0; i < 6; i++) push_rx(8'hA0 + 8'(i));
      rd_rx(2'd2, d);
      check("R3 word read", d, 32'hA3A2A1A0);
      check("R3 level after word", level_o, 32'h0002_0000);
      rd_rx(2'd1, d);
      check("R3 half read", d, 32'h0000A5A4);
      check("R8 no underflow", 32'(rx_unf), 32'h0);
   endtask

   task automatic t_underflow;
      logic [31:0] d;
      push_rx(8'hB0); push_rx(8'hB1);
      rd_rx(2'd3, d);
      check("R8 short word read", d, 32'h0000B1B0);
      check("R8 unf set", 32'(rx_unf), 32'h1);
      check("R8 level zero", level_o, 32'h0);
      rd_rx(2'd0, d);
      check("R8 empty read zero", d, 32'h0);
      ctl(0, 0, 0, 1);
      check("R9 rx flush clears unf", 32'(rx_unf), 32'h0);
   endtask

   task automatic t_tx_thresh;
      set_thr(2'd2, 2'd0);
      check("R5 four, empty", 32'(tx_ready), 32'h1);
      for (int i = 0; i < 7; i++) wr_tx(2'd2, 32'h01020304);
      check("R5 level 28", level_o, 32'd28);
      check("R5 four, free 4", 32'(tx_ready), 32'h1);
      wr_tx(2'd0, 32'h5);
      check("R5 four, free 3", 32'(tx_ready), 32'h0);
      set_thr(2'd1, 2'd0);
      check("R5 two, free 3", 32'(tx_ready), 32'h1);
      wr_tx(2'd1, 32'h0606);
      check("R5 two, free 1", 32'(tx_ready), 32'h0);
      set_thr(2'd0, 2'd0);
      check("R5 one, free 1", 32'(tx_ready), 32'h1);
      set_thr(2'd3, 2'd0);
      check("R5 code3, free 1", 32'(tx_ready), 32'h1);
      wr_tx(2'd0, 32'h7);
      check("R5 full level", level_o, 32'd32);
      check("R5 full not ready", 32'(tx_ready), 32'h0);
      // same-cycle shifter pop and byte write on a full FIFO
      @(negedge clk); sh_tx_pop = 1; thr_wr = 1; thr_size = 2'd0; thr_wdata = 32'h8;
      @(negedge clk); sh_tx_pop = 0; thr_wr = 0; #1;
      check("R7 push judged on start count", level_o, 32'd31);
      check("R7 ovf on full", 32'(tx_ovf), 32'h1);
      ctl(0, 0, 1, 0);
      check("R9 tx flush empties", level_o, 32'h0);
      check("R9 tx flush clears ovf", 32'(tx_ovf), 32'h0);
      set_thr(2'd0, 2'd0);
   endtask

   task automatic t_rx_thresh;
      logic [31:0] d;
      set_thr(2'd0, 2'd2);
      for (int i = 0; i < 3; i++) push_rx(8'(i));
      check("R6 four, held 3", 32'(rx_ready), 32'h0);
      push_rx(8'h3);
      check("R6 four, held 4", 32'(rx_ready), 32'h1);
      set_thr(2'd0, 2'd1);
      rd_rx(2'd1, d);
      check("R6 two, held 2", 32'(rx_ready), 32'h1);
      rd_rx(2'd0, d);
      check("R6 two, held 1", 32'(rx_ready), 32'h0);
      set_thr(2'd0, 2'd0);
      check("R6 one, held 1", 32'(rx_ready), 32'h1);
      set_thr(2'd0, 2'd3);
      check("R6 code3, held 1", 32'(rx_ready), 32'h1);
      ctl(0, 0, 0, 1);
      set_thr(2'd0, 2'd0);
   endtask

   task automatic t_level;
      wr_tx(2'd1, 32'h0201);
      wr_tx(2'd0, 32'h03);
      for (int i = 0; i < 5; i++) push_rx(8'h40);
      check("R10 level fields", level_o, 32'h0005_0003);
      check("R11 valid when stored", 32'(sh_tx_valid), 32'h1);
      ctl(0, 0, 1, 1);
   endtask

   task automatic t_ctl;
      for (int i = 0; i < 33; i++) push_rx(8'(i));
      check("R11 rx full drop", level_o, 32'h0020_0000);
      wr_tx(2'd2, 32'h11111111);
      @(negedge clk); ctl_tx_flush = 1; thr_wr = 1; thr_size = 2'd0; thr_wdata = 32'h9;
      @(negedge clk); ctl_tx_flush = 0; thr_wr = 0; #1;
      check("R9 flush beats push", level_o[5:0], 32'h0);
      ctl(1, 1, 0, 0);
      check("R9 on+off empties both", level_o, 32'h0);
      wr_tx(2'd2, 32'h12345678);
      check("R9 off wins, one byte", level_o, 32'h1);
      check("R4 off wins lane0", 32'(sh_tx_byte), 32'h78);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1; #1;
      t_reset;
      t_fifo_off;
      t_tx_order;
      t_rx_word;
      t_underflow;
      t_tx_thresh;
      t_rx_thresh;
      t_level;
      t_ctl;
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         done = 1;
         n_chk++; n_err++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

endmodule